// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the interrupt sources of a UART into one request line and one 8-bit identification byte that software reads to find out why it was interrupted. It takes four event conditions: receive line errors (such as an overrun into a full receive FIFO), receive data available, character timeout, and a one-cycle pulse when the transmit holding register empties. It also takes a 3-bit enable mask, a flag saying whether the FIFOs are on, and a strobe that marks a read of the identification byte.

The line-status, receive-data and timeout inputs are levels, held by the logic that produces them until that logic services them. The transmit-empty pulse is latched inside the block. The latch is cleared when software reads the identification byte while that source is the one being reported. Only the most urgent enabled source is reported. Bit 0 of the byte is active low, and the request line is its inverse.

Top module: `uart_int_ident`

## Requirements
- R1: With no enabled source pending, `intId[0]` is 1 and `intId[3:1]` is 000. With any enabled source pending, `intId[0]` is 0.
- R2: `irq` always equals the inverse of `intId[0]`.
- R3: `intId[7:6]` is 11 when `fifoEnabled` is 1 and 00 when it is 0. `intId[5:4]` is always 00.
- R4: When `lineStatusEvt` is high and `enableMask[2]` is 1, `intId[3:1]` is 011, whatever the other sources are doing.
- R5: When `rxDataAvail` is high, `enableMask[0]` is 1 and no line-status source is enabled and pending, `intId[3:1]` is 010. This holds even if a timeout is also pending.
- R6: `charTimeout` is gated by `enableMask[0]`. When it is the highest enabled source, `intId[3:1]` is 110.
- R7: A one-cycle `txEmptyEvt` pulse sets a pending flag, visible from the next cycle. While `enableMask[1]` is 1 and no higher source is enabled and pending, the flag is reported as `intId[3:1]` = 001. The flag stays set until it is cleared.
- R8: A cycle with `idRead` high while code 001 is reported clears the flag from the next cycle on. If `txEmptyEvt` is also high in that cycle, the flag stays set.
- R9: An `idRead` while the transmit-empty flag is set but not reported (it is masked, or a higher source is pending) leaves the flag set.
- R10: Reset clears the transmit-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStatusEvt | input | 1 | Receive line error condition (level) |
| rxDataAvail | input | 1 | Receive data available condition (level) |
| charTimeout | input | 1 | Character timeout condition (level) |
| txEmptyEvt | input | 1 | One-cycle pulse: transmit holding register emptied |
| enableMask | input | 3 | bit0 receive data and timeout, bit1 transmit empty, bit2 line status |
| fifoEnabled | input | 1 | FIFOs enabled flag, reported in the upper bits |
| idRead | input | 1 | Strobe: identification byte is being read |
| irq | output | 1 | Interrupt request, active high |
| intId | output | 8 | Identification byte |

## Verification
The only state in the block is the transmit-empty flag. A flag stuck low shows up as a missing 001 code and a low `irq` on the cycle after the pulse. A flag that never clears keeps showing 001 on the cycle after a read. All other output bits are combinational, so a wrong mask, priority or code shows up at the ports in the same cycle as the input pattern that causes it. The bench therefore samples one settle delay after each change.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_NONE    = 3'b000;
  localparam logic [CODE_W-1:0] CODE_LINE    = 3'b011;
  localparam logic [CODE_W-1:0] CODE_RXDATA  = 3'b010;
  localparam logic [CODE_W-1:0] CODE_TIMEOUT = 3'b110;
  localparam logic [CODE_W-1:0] CODE_TXEMPTY = 3'b001;

  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LINE = 2;

  typedef struct packed {
    logic selLine;
    logic selRxData;
    logic selTimeout;
    logic selTxEmpty;
  } iidSel_t;
endpackage

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
#(
  parameter int EN_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineStatusEvt,
  input  logic            rxDataAvail,
  input  logic            charTimeout,
  input  logic            txEmptyEvt,
  input  logic [EN_W-1:0] enableMask,
  input  logic            idRead,
  output iidSel_t         sel
);
  logic txPend;
  logic lineReq, rxReq, toReq, txReq;

  always_comb begin
    lineReq = lineStatusEvt & enableMask[EN_LINE];
    rxReq   = rxDataAvail   & enableMask[EN_RX];
    toReq   = charTimeout   & enableMask[EN_RX];
    txReq   = txPend        & enableMask[EN_TX];
  end

  // fixed priority: line > rx data > timeout > tx empty
  always_comb begin
    sel = '0;
    if (lineReq)    sel.selLine    = 1'b1;
    else if (rxReq) sel.selRxData  = 1'b1;
    else if (toReq) sel.selTimeout = 1'b1;
    else if (txReq) sel.selTxEmpty = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           txPend <= 1'b0;
    else if (txEmptyEvt)                 txPend <= 1'b1;
    else if (idRead && sel.selTxEmpty)   txPend <= 1'b0;
  end
endmodule

// File: rtl/uart_iid_data.sv
module uart_iid_data
  import uart_iid_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int STAT_W = 2
) (
  input  iidSel_t         sel,
  input  logic            fifoEnabled,
  output logic [ID_W-1:0] intId,
  output logic            irq
);
  localparam int RSV_W = ID_W - STAT_W - CODE_W - 1;

  logic [CODE_W-1:0] code;
  logic              anyPend;

  always_comb begin
    unique case (1'b1)
      sel.selLine:    code = CODE_LINE;
      sel.selRxData:  code = CODE_RXDATA;
      sel.selTimeout: code = CODE_TIMEOUT;
      sel.selTxEmpty: code = CODE_TXEMPTY;
      default:        code = CODE_NONE;
    endcase
    anyPend = |sel;
    intId   = {{STAT_W{fifoEnabled}}, {RSV_W{1'b0}}, code, ~anyPend};
    irq     = anyPend;
  end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_iid_pkg::*;
#(
  parameter int EN_W   = 3,
  parameter int ID_W   = 8,
  parameter int STAT_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineStatusEvt,
  input  logic            rxDataAvail,
  input  logic            charTimeout,
  input  logic            txEmptyEvt,
  input  logic [EN_W-1:0] enableMask,
  input  logic            fifoEnabled,
  input  logic            idRead,
  output logic            irq,
  output logic [ID_W-1:0] intId
);
  iidSel_t sel;

  uart_iid_ctrl #(.EN_W(EN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lineStatusEvt(lineStatusEvt), .rxDataAvail(rxDataAvail),
    .charTimeout(charTimeout), .txEmptyEvt(txEmptyEvt),
    .enableMask(enableMask), .idRead(idRead), .sel(sel)
  );

  uart_iid_data #(.ID_W(ID_W), .STAT_W(STAT_W)) u_data (
    .sel(sel), .fifoEnabled(fifoEnabled), .intId(intId), .irq(irq)
  );
endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lineStatusEvt,
  input logic       rxDataAvail,
  input logic       charTimeout,
  input logic       txEmptyEvt,
  input logic [2:0] enableMask,
  input logic       fifoEnabled,
  input logic       idRead,
  input logic       irq,
  input logic [7:0] intId
);
  // R2
  irq_polarity_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == !intId[0]);

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    intId[0] |-> intId[3:1] == 3'b000);

  // R3
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    intId[7:4] == {fifoEnabled, fifoEnabled, 2'b00});

  // R4
  line_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStatusEvt && enableMask[2]) |-> (intId[3:0] == 4'b0110));

  // R6
  timeout_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intId[3:1] == 3'b110) |-> (charTimeout && enableMask[0] && !rxDataAvail));

  // R7
  tx_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyEvt |=> (!(enableMask[1] && !(lineStatusEvt && enableMask[2]) &&
                      !((rxDataAvail || charTimeout) && enableMask[0]))
                    || intId[3:0] == 4'b0010));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idRead && intId[3:1] == 3'b001 && !txEmptyEvt) |=> intId[3:1] != 3'b001);
endmodule

bind uart_int_ident uart_iid_chk u_chk (
  .clk(clk), .rstN(rstN), .lineStatusEvt(lineStatusEvt),
  .rxDataAvail(rxDataAvail), .charTimeout(charTimeout),
  .txEmptyEvt(txEmptyEvt), .enableMask(enableMask),
  .fifoEnabled(fifoEnabled), .idRead(idRead), .irq(irq), .intId(intId)
);

// File: tb/tb_uart_int_ident.sv
module tb_uart_int_ident;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStatusEvt = 1'b0, rxDataAvail = 1'b0, charTimeout = 1'b0;
  logic       txEmptyEvt = 1'b0, fifoEnabled = 1'b0, idRead = 1'b0;
  logic [2:0] enableMask = 3'b000;
  logic       irq;
  logic [7:0] intId;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  uart_int_ident dut (
    .clk(clk), .rstN(rstN), .lineStatusEvt(lineStatusEvt),
    .rxDataAvail(rxDataAvail), .charTimeout(charTimeout),
    .txEmptyEvt(txEmptyEvt), .enableMask(enableMask),
    .fifoEnabled(fifoEnabled), .idRead(idRead), .irq(irq), .intId(intId)
  );

  // vector: {line, rxData, timeout, enable[2:0], fifo, expected id[7:0]}
  localparam int NVEC = 9;
  localparam logic [14:0] VEC [NVEC] = '{
    {3'b000, 3'b111, 1'b0, 8'h01},  // R1 idle
    {3'b100, 3'b111, 1'b1, 8'hC6},  // R4 line, R3 fifo bits
    {3'b010, 3'b111, 1'b0, 8'h04},  // R5 rx data
    {3'b001, 3'b111, 1'b1, 8'hCC},  // R6 timeout
    {3'b011, 3'b111, 1'b0, 8'h04},  // R5 rx data beats timeout
    {3'b110, 3'b001, 1'b0, 8'h04},  // R4 line masked
    {3'b111, 3'b110, 1'b0, 8'h06},  // R4 line over masked rx
    {3'b011, 3'b110, 1'b0, 8'h01},  // R6 timeout masked by bit0
    {3'b100, 3'b011, 1'b1, 8'hC1}   // R1 R3 masked line, fifo on
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chkId(input string req, input logic [7:0] exp);
    chk(req, intId, exp);
    chk("R2", {7'b0, irq}, {7'b0, ~exp[0]});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    enableMask = 3'b111;
    step();
    step();
    #1 chkId("R1 reset state", 8'h01);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {lineStatusEvt, rxDataAvail, charTimeout} = VEC[i][14:12];
      enableMask  = VEC[i][11:9];
      fifoEnabled = VEC[i][8];
      #1 chkId($sformatf("vector %0d R1/R3/R4/R5/R6", i), VEC[i][7:0]);
    end

    @(negedge clk);
    {lineStatusEvt, rxDataAvail, charTimeout} = 3'b000;
    enableMask = 3'b111;
    fifoEnabled = 1'b0;

    // R7 pulse latches
    txEmptyEvt = 1'b1;
    step();
    txEmptyEvt = 1'b0;
    #1 chkId("R7 tx empty reported", 8'h02);
    step();
    step();
    #1 chkId("R7 tx empty held", 8'h02);

    // R9 read while higher source shown
    @(negedge clk) rxDataAvail = 1'b1;
    #1 chkId("R5 rx over tx empty", 8'h04);
    idRead = 1'b1;
    step();
    idRead = 1'b0;
    rxDataAvail = 1'b0;
    #1 chkId("R9 read under rx keeps tx", 8'h02);

    // R9 read while masked
    @(negedge clk) enableMask = 3'b101;
    #1 chkId("R7 masked tx hidden", 8'h01);
    idRead = 1'b1;
    step();
    idRead = 1'b0;
    enableMask = 3'b111;
    #1 chkId("R9 masked read keeps tx", 8'h02);

    // R8 set wins over clear in the same cycle
    @(negedge clk);
    idRead = 1'b1;
    txEmptyEvt = 1'b1;
    step();
    idRead = 1'b0;
    txEmptyEvt = 1'b0;
    #1 chkId("R8 event with read keeps flag", 8'h02);

    // R8 read clears
    @(negedge clk) idRead = 1'b1;
    step();
    idRead = 1'b0;
    #1 chkId("R8 read clears tx", 8'h01);
    step();
    #1 chkId("R8 stays clear", 8'h01);

    // R10 reset clears flag
    @(negedge clk) txEmptyEvt = 1'b1;
    step();
    txEmptyEvt = 1'b0;
    #1 chkId("R7 set before reset", 8'h02);
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    #1 chkId("R10 reset clears tx flag", 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule